// File: doc/BRIEF.md
# UART Line Status Tracker

This block holds the read-only line status word of a 16550-class serial port. It takes one-cycle strobes from the receiver: a character has arrived, with its parity, framing and break flags alongside. It also takes the receive-buffer read strobe, empty and full levels from the transmitter, a FIFO enable, a programmable transmit-empty mode enable and a status-read strobe. It owns the receive store. With the FIFO enabled the store is a 16-entry queue. Each entry keeps the character next to three error tag bits, so an error becomes visible only when its character reaches the head.

With the FIFO disabled the store acts as a single holding register. A new character overwrites it and its errors show at once. The parity, framing, break and overrun flags are sticky and are cleared by a status read. The read itself still sees the value held before the clear. Bit 7 is an aggregate flag meaning that some queued character carries an error. It is driven by a count of tagged entries and survives reads until the last tagged character is at the head.

The word is 32 bits wide. Bit layout: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 transmit holding empty (or TX FIFO full in programmable mode), 6 transmitter empty, 7 receive FIFO error. Bits 31:8 are zero.

Top module: `uart_lsr_tracker`

## Requirements
- R1: While reset is asserted and after it, before any event, the status word reads 0x00000060. Bits 31:8 always read zero.
- R2: Bit 0 is 1 whenever the receive store holds a character. A receive read (`rxPop`) of the last held character clears it on the following cycle.
- R3: FIFO disabled: a character that arrives while one is already held, with no read in the same cycle, overwrites the held character and sets bit 1.
- R4: FIFO enabled: a character that arrives while 16 characters are held, with no read in the same cycle, is dropped and sets bit 1. The queued characters and their order are unchanged.
- R5: Tag inputs parity, framing and break map to bits 2, 3 and 4. FIFO enabled: a tag reaches its bit only when its character becomes the head entry. FIFO disabled: it reaches its bit on the cycle after arrival.
- R6: A status read sees the pre-clear value and clears bits 1 to 4 on the next cycle. An error revealed in the same cycle as the read is set afterwards. Without a read, these bits hold.
- R7: Bit 7 sets on the cycle after a tagged character enters the enabled FIFO. A status read clears it only when no tagged entry remains, or when exactly one remains and it is the head. It is 0 whenever the FIFO is disabled.
- R8: Bit 6 equals transmit-buffer-empty AND shift-register-empty, registered once.
- R9: Bit 5 equals the registered TX FIFO full input when both programmable mode and the FIFO are enabled. Otherwise it equals the registered transmit-buffer-empty input.
- R10: A change of `fifoEn` empties the receive store and takes one cycle. Receive strobes in that cycle are ignored. Bits 2 to 4 keep their values.
- R11: `rxHead` shows the head character. A receive read of an empty store has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | Receive and transmit FIFOs enabled |
| progThreEn | input | 1 | Programmable transmit-empty mode enable |
| rxValid | input | 1 | One-cycle strobe: character received |
| rxData | input | 8 | Received character |
| rxParErr | input | 1 | Parity error tag, valid with rxValid |
| rxFrmErr | input | 1 | Framing error tag, valid with rxValid |
| rxBreak | input | 1 | Break tag, valid with rxValid |
| rxPop | input | 1 | One-cycle strobe: receive buffer read |
| rxHead | output | 8 | Character at the head of the receive store |
| txHoldEmpty | input | 1 | Transmit holding register or TX FIFO empty |
| txShiftEmpty | input | 1 | Transmit shift register empty |
| txFifoFull | input | 1 | TX FIFO full |
| statusRd | input | 1 | One-cycle strobe: status word read |
| statusWord | output | 32 | Line status word |

## Verification
A wrong write or read pointer shows on `rxHead` at the next receive read. It also shows in the cycle at which bit 0 falls. A tag stored against the wrong entry makes bits 2 to 4 appear one receive read too early or too late. A miscounted tagged-entry total shows as bit 7 surviving, or vanishing on, the status read that should decide it. An overrun mishandled at the capacity limit changes the sixteenth popped character.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int TAG_W   = 3;
  localparam int TAG_PAR = 0;
  localparam int TAG_FRM = 1;
  localparam int TAG_BRK = 2;

  typedef struct packed {
    logic flush;
    logic push;
    logic overwrite;
    logic pop;
    logic setOverrun;
    logic revealIn;
    logic revealNext;
    logic clrSticky;
    logic rfeSet;
    logic rfeClr;
    logic countUp;
    logic countDown;
  } lsrCtl_t;
endpackage

// File: rtl/lsr_control.sv
module lsr_control
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             rxValid,
  input  logic [TAG_W-1:0] rxTag,
  input  logic             rxPop,
  input  logic             statusRd,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] errCnt,
  input  logic [TAG_W-1:0] headTag,
  output lsrCtl_t          ctl
);
  logic modeFifo;
  logic flush, empty, full, popOk, arrive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeFifo <= 1'b0;
    else       modeFifo <= fifoEn;
  end

  always_comb begin
    flush  = (fifoEn != modeFifo);
    empty  = (count == '0);
    full   = modeFifo ? (count == CNT_W'(DEPTH)) : (count == CNT_W'(1));
    popOk  = rxPop && !empty && !flush;
    arrive = rxValid && !flush;

    ctl            = '0;
    ctl.flush      = flush;
    ctl.pop        = popOk;
    ctl.push       = arrive && (!full || popOk);
    ctl.overwrite  = arrive && full && !popOk && !modeFifo;
    ctl.setOverrun = arrive && full && !popOk;
    ctl.revealIn   = (ctl.push && (empty || (popOk && count == CNT_W'(1)))) || ctl.overwrite;
    ctl.revealNext = popOk && (count > CNT_W'(1));
    ctl.clrSticky  = statusRd;
    ctl.countUp    = modeFifo && ctl.push && (|rxTag);
    ctl.countDown  = modeFifo && popOk && (|headTag);
    ctl.rfeSet     = ctl.countUp;
    ctl.rfeClr     = flush || !modeFifo ||
                     (statusRd && ((errCnt == '0) ||
                                   ((errCnt == CNT_W'(1)) && (|headTag))));
  end
endmodule

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DATA_W   = 8,
  parameter int STATUS_W = 32,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  lsrCtl_t             ctl,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [TAG_W-1:0]    rxTag,
  input  logic                fifoEn,
  input  logic                progThreEn,
  input  logic                txHoldEmpty,
  input  logic                txShiftEmpty,
  input  logic                txFifoFull,
  output logic [CNT_W-1:0]    count,
  output logic [CNT_W-1:0]    errCnt,
  output logic [TAG_W-1:0]    headTag,
  output logic [DATA_W-1:0]   rxHead,
  output logic [STATUS_W-1:0] statusWord
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [TAG_W-1:0]  tagMem  [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrAddr;
  logic [TAG_W-1:0]  nextTag, revealTag, errSticky;
  logic              overrunQ, rfeQ, threQ, temtQ;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wrAddr  = ctl.overwrite ? rdPtr : wrPtr;
  assign headTag = tagMem[rdPtr];
  assign nextTag = tagMem[bump(rdPtr)];
  assign rxHead  = dataMem[rdPtr];

  always_ff @(posedge clk) begin
    if (ctl.push || ctl.overwrite) begin
      dataMem[wrAddr] <= rxData;
      tagMem[wrAddr]  <= rxTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      errCnt <= '0;
    end else if (ctl.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      errCnt <= '0;
    end else begin
      if (ctl.push) wrPtr <= bump(wrPtr);
      if (ctl.pop)  rdPtr <= bump(rdPtr);
      count  <= count + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
      errCnt <= errCnt + CNT_W'(ctl.countUp) - CNT_W'(ctl.countDown);
    end
  end

  always_comb begin
    revealTag = '0;
    if (ctl.revealIn)        revealTag = rxTag;
    else if (ctl.revealNext) revealTag = nextTag;
  end

  for (genvar g = 0; g < TAG_W; g++) begin : g_sticky
    logic flagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ <= 1'b0;
      else       flagQ <= (flagQ & ~ctl.clrSticky) | revealTag[g];
    end
    assign errSticky[g] = flagQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunQ <= 1'b0;
      rfeQ     <= 1'b0;
      threQ    <= 1'b1;
      temtQ    <= 1'b1;
    end else begin
      overrunQ <= (overrunQ & ~ctl.clrSticky) | ctl.setOverrun;
      if (ctl.rfeSet)      rfeQ <= 1'b1;
      else if (ctl.rfeClr) rfeQ <= 1'b0;
      threQ <= (progThreEn && fifoEn) ? txFifoFull : txHoldEmpty;
      temtQ <= txHoldEmpty && txShiftEmpty;
    end
  end

  always_comb begin
    statusWord    = '0;
    statusWord[0] = (count != '0);
    statusWord[1] = overrunQ;
    statusWord[2] = errSticky[TAG_PAR];
    statusWord[3] = errSticky[TAG_FRM];
    statusWord[4] = errSticky[TAG_BRK];
    statusWord[5] = threQ;
    statusWord[6] = temtQ;
    statusWord[7] = rfeQ;
  end
endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
  import lsr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              progThreEn,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              rxBreak,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxHead,
  input  logic              txHoldEmpty,
  input  logic              txShiftEmpty,
  input  logic              txFifoFull,
  input  logic              statusRd,
  output logic [31:0]       statusWord
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  lsrCtl_t          ctl;
  logic [TAG_W-1:0] rxTag, headTag;
  logic [CNT_W-1:0] count, errCnt;

  always_comb begin
    rxTag          = '0;
    rxTag[TAG_PAR] = rxParErr;
    rxTag[TAG_FRM] = rxFrmErr;
    rxTag[TAG_BRK] = rxBreak;
  end

  lsr_control #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxValid(rxValid), .rxTag(rxTag),
    .rxPop(rxPop), .statusRd(statusRd), .count(count), .errCnt(errCnt),
    .headTag(headTag), .ctl(ctl)
  );

  lsr_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STATUS_W(32)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData), .rxTag(rxTag),
    .fifoEn(fifoEn), .progThreEn(progThreEn), .txHoldEmpty(txHoldEmpty),
    .txShiftEmpty(txShiftEmpty), .txFifoFull(txFifoFull), .count(count),
    .errCnt(errCnt), .headTag(headTag), .rxHead(rxHead), .statusWord(statusWord)
  );
endmodule

// File: rtl/lsr_tracker_checker.sv
module lsr_tracker_checker (
  input logic        clk,
  input logic        rstN,
  input logic        fifoEn,
  input logic        progThreEn,
  input logic        rxValid,
  input logic        statusRd,
  input logic        txHoldEmpty,
  input logic        txShiftEmpty,
  input logic [31:0] statusWord,
  input logic        ctlPop,
  input logic        ctlFlush,
  input logic        ctlOverrun
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:8] == 24'h0);

  a_r2_ready_falls: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusWord[0]) |-> $past(ctlPop || ctlFlush));

  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    ctlOverrun |=> statusWord[1]);

  a_r6_overrun_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !rxValid) |=> !statusWord[1]);

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !statusRd |=> ((statusWord[4:2] & $past(statusWord[4:2])) == $past(statusWord[4:2])));

  a_r7_rfe_off: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |=> !statusWord[7]);

  a_r8_temt: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusWord[6] == $past(txHoldEmpty && txShiftEmpty));

  a_r9_thre_plain: assert property (@(posedge clk) disable iff (!rstN)
    !(progThreEn && fifoEn) |=> statusWord[5] == $past(txHoldEmpty));
endmodule

bind uart_lsr_tracker lsr_tracker_checker i_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .progThreEn(progThreEn),
  .rxValid(rxValid), .statusRd(statusRd), .txHoldEmpty(txHoldEmpty),
  .txShiftEmpty(txShiftEmpty), .statusWord(statusWord),
  .ctlPop(ctl.pop), .ctlFlush(ctl.flush), .ctlOverrun(ctl.setOverrun)
);

// File: tb/test_uart_lsr_tracker.sv
module test_uart_lsr_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 9;
  // row: {fe, valid, data[7:0], tags{brk,frm,par}, pop, rd, expected[7:0], reqNum[3:0]}
  localparam logic [26:0] ROWS [NROWS] = '{
    {1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 8'h60, 4'd1},  // R1 idle
    {1'b0, 1'b1, 8'hA5, 3'b000, 1'b0, 1'b0, 8'h61, 4'd2},  // R2 char held
    {1'b0, 1'b1, 8'h3C, 3'b000, 1'b0, 1'b0, 8'h63, 4'd3},  // R3 overwrite
    {1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h61, 4'd6},  // R6 read clears OE
    {1'b0, 1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h60, 4'd2},  // R2 pop clears DR
    {1'b0, 1'b1, 8'h00, 3'b110, 1'b0, 1'b0, 8'h79, 4'd5},  // R5 immediate break+frame
    {1'b0, 1'b1, 8'h55, 3'b001, 1'b0, 1'b1, 8'h67, 4'd6},  // R6 read with new error
    {1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h61, 4'd6},  // R6 read clears
    {1'b0, 1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h60, 4'd11}  // R11 pop
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic fifoEn = 1'b0, progThreEn = 1'b0, rxValid = 1'b0, rxPop = 1'b0, statusRd = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic rxParErr = 1'b0, rxFrmErr = 1'b0, rxBreak = 1'b0;
  logic txHoldEmpty = 1'b0, txShiftEmpty = 1'b0, txFifoFull = 1'b1;
  logic [7:0] rxHead;
  logic [31:0] statusWord;
  logic [31:0] preVal;
  int checks = 0, fails = 0;

  uart_lsr_tracker i_uart_lsr_tracker (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .progThreEn(progThreEn),
    .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr), .rxFrmErr(rxFrmErr),
    .rxBreak(rxBreak), .rxPop(rxPop), .rxHead(rxHead), .txHoldEmpty(txHoldEmpty),
    .txShiftEmpty(txShiftEmpty), .txFifoFull(txFifoFull), .statusRd(statusRd),
    .statusWord(statusWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic fe, input logic v, input logic [7:0] d,
                      input logic [2:0] tags, input logic pop, input logic rd);
    @(negedge clk);
    fifoEn = fe; rxValid = v; rxData = d;
    {rxBreak, rxFrmErr, rxParErr} = tags;
    rxPop = pop; statusRd = rd;
    #1 preVal = statusWord;
    @(posedge clk);
    @(negedge clk);
    rxValid = 1'b0; rxPop = 1'b0; statusRd = 1'b0;
    {rxBreak, rxFrmErr, rxParErr} = 3'b000;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", statusWord, 32'h60);
    rstN = 1'b1;
    txHoldEmpty = 1'b1; txShiftEmpty = 1'b1; txFifoFull = 1'b0;
    @(negedge clk);
    check("R1 after reset", statusWord, 32'h60);

    for (int i = 0; i < NROWS; i++) begin
      logic [26:0] r;
      r = ROWS[i];
      step(r[26], r[25], r[24:17], r[16:14], r[13], r[12]);
      checks++;
      if (statusWord !== {24'h0, r[11:4]}) begin
        fails++;
        $display("FAIL R%0d row %0d: actual %h expected %h", r[3:0], i, statusWord, r[11:4]);
      end
      if (i == 2) check("R3 overwritten data", {24'h0, rxHead}, 32'h3C);
      if (i == 3) check("R6 read sees pre-clear value", preVal, 32'h63);
    end

    // R10: enabling FIFO flushes
    step(1, 0, 8'h00, 3'b000, 0, 0);
    check("R10 flush on enable", statusWord, 32'h60);

    // R5 / R7 deferred reveal
    step(1, 1, 8'h11, 3'b000, 0, 0);
    step(1, 1, 8'h22, 3'b001, 0, 0);
    step(1, 1, 8'h33, 3'b000, 0, 0);
    check("R5 R7 tag hidden, rfe set", statusWord, 32'hE1);
    check("R11 head data", {24'h0, rxHead}, 32'h11);
    step(1, 0, 8'h00, 3'b000, 0, 1);
    check("R7 rfe survives read", statusWord, 32'hE1);
    step(1, 0, 8'h00, 3'b000, 1, 0);
    check("R5 parity revealed at head", statusWord, 32'hE5);
    check("R11 head advanced", {24'h0, rxHead}, 32'h22);
    step(1, 0, 8'h00, 3'b000, 0, 1);
    check("R7 read clears rfe", statusWord, 32'h61);
    step(1, 0, 8'h00, 3'b000, 1, 0);
    step(1, 0, 8'h00, 3'b000, 1, 0);
    check("R2 fifo drained", statusWord, 32'h60);
    step(1, 0, 8'h00, 3'b000, 1, 0);
    check("R11 pop on empty ignored", statusWord, 32'h60);

    // R4 FIFO overrun
    for (int k = 1; k <= 16; k++) step(1, 1, 8'(k), 3'b000, 0, 0);
    check("R2 full fifo ready", statusWord, 32'h61);
    step(1, 1, 8'hEE, 3'b000, 0, 0);
    check("R4 overrun when full", statusWord, 32'h63);
    check("R4 head kept", {24'h0, rxHead}, 32'h01);
    step(1, 0, 8'h00, 3'b000, 0, 1);
    for (int k = 0; k < 15; k++) step(1, 0, 8'h00, 3'b000, 1, 0);
    check("R4 last entry kept", {24'h0, rxHead}, 32'h10);
    check("R2 one left", statusWord, 32'h61);
    step(1, 0, 8'h00, 3'b000, 1, 0);
    check("R2 cleared when fifo empty", statusWord, 32'h60);

    // R7 two tagged entries
    step(1, 1, 8'h44, 3'b001, 0, 0);
    step(1, 1, 8'h45, 3'b010, 0, 0);
    check("R5 head reveals on push to empty", statusWord, 32'hE5);
    step(1, 0, 8'h00, 3'b000, 0, 1);
    check("R7 rfe kept, later error queued", statusWord, 32'hE1);
    step(1, 0, 8'h00, 3'b000, 1, 0);
    check("R5 framing revealed", statusWord, 32'hE9);
    step(1, 0, 8'h00, 3'b000, 0, 1);
    check("R7 rfe cleared, last tag at head", statusWord, 32'h61);
    step(1, 0, 8'h00, 3'b000, 1, 0);

    // R8 / R9 transmitter bits
    txHoldEmpty = 1'b0; txFifoFull = 1'b1; progThreEn = 1'b1;
    step(1, 0, 8'h00, 3'b000, 0, 0);
    check("R8 R9 programmable mode full", statusWord, 32'h20);
    progThreEn = 1'b0;
    step(1, 0, 8'h00, 3'b000, 0, 0);
    check("R9 plain mode", statusWord, 32'h00);
    txHoldEmpty = 1'b1; txFifoFull = 1'b0;
    step(1, 0, 8'h00, 3'b000, 0, 0);
    check("R8 transmitter empty", statusWord, 32'h60);

    // R10 disabling flushes, drops rfe, keeps flags
    step(1, 1, 8'h77, 3'b001, 0, 0);
    check("R7 tagged push", statusWord, 32'hE5);
    step(0, 0, 8'h00, 3'b000, 0, 0);
    check("R10 flush on disable", statusWord, 32'h64);
    step(0, 0, 8'h00, 3'b000, 0, 1);
    check("R6 final read", statusWord, 32'h60);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule